// File: doc/BRIEF.md
# Automatic Gain Control Loop with PWM Gain Output

This block closes the gain loop in front of a pair of 6-bit I/Q converters. It squares both samples, adds them and sums the result over a window of sixteen valid samples. The top byte of that 16-bit sum is its level estimate. It drives an 8-bit gain value out of a single pin as a pulse-width-modulated waveform. An external RC filter turns that waveform into the analog gain control voltage.

There are two modes. In slave mode, a host reads the level estimate and writes the gain, and the written value drives the PWM duty directly. In master mode, the same written byte is a target level instead. Each time a programmable number of windows has elapsed, the block moves its own gain one step towards the value that brings the level estimate to that target.

A small register port with address, write data, write strobe and read strobe gives access to the level, the gain or target byte, the mode, the update interval and the output polarity.

Top module: `agc_pwm_loop`

## Requirements
- R1: After reset the level register reads 00h and the gain/target register reads 00h. The control register reads 10h: slave mode, interval code 0, positive polarity. The internal master-mode gain is 80h, and pwm_out stays low.
- R2: Samples are two's complement and are taken only in cycles where smp_vld is high. After every 16th valid sample since reset, the level register (address 0h) becomes floor(S/256). S is the sum of I*I+Q*Q over those 16 samples, saturated at FFFFh.
- R3: The level register holds its value between window closures. I/Q values presented with smp_vld low have no effect.
- R4: Address 4h is the read/write gain/target byte. Address 7h is the read/write control byte: bit 0 is mode (1 = master), bits 3:1 are interval code T, bit 4 is polarity (1 = positive), and bits 7:5 read 0. Other addresses read 00h, and writes to them are ignored.
- R5: reg_rdata is loaded in the cycle after a clock edge where reg_rd is high. It holds its value at all other times.
- R6: In slave mode the PWM duty is the gain/target byte. The level has no influence.
- R7: In master mode, after every 2^(T+4) closed windows, the internal gain rises by one if the level is below the target. It falls by one if the level is above the target, and holds if the two are equal.
- R8: The internal gain saturates at FFh going up and at 00h going down.
- R9: The PWM period is 256 clocks. With positive polarity the output is high for the first N clocks of a period, where N is the active gain. A gain change takes effect only at the next period start.
- R10: With polarity bit 0 the output is the complement of the positive waveform.
- R11: While in slave mode the interval counter is held at zero and the internal gain keeps its value. Returning to master mode resumes from that gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_i | input | 6 | In-phase sample, two's complement |
| smp_q | input | 6 | Quadrature sample, two's complement |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data |
| pwm_out | output | 1 | PWM gain output |

## Verification
The level estimate is tested in three ways:
- Random sample windows with random idle gaps show that only valid samples count and that windows stay aligned.
- All-negative full-scale windows and mixed-extreme windows separate signed from unsigned squaring.
- Idle cycles with changing sample values confirm the level holds between window closures.

The master loop is tested with three target settings:
- A target below the level checks downward steps.
- A target equal to the level checks the hold case.
- A target above the level checks upward steps.

Long runs against FFh and 00h expose missing saturation. A run of 31 and then 32 windows at interval code 1 tells a correct update interval from an off-by-one one. The PWM is checked by measuring high time over whole periods, and by writing a new gain in the middle of a high pulse, which shows whether the duty is latched only at the period boundary.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int ADDR_W = 3;
  localparam int TMR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_LEVEL = 3'h0;
  localparam logic [ADDR_W-1:0] ADR_GAIN  = 3'h4;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'h7;

  typedef struct packed {
    logic             pos;     // bit 4: 1 = positive polarity
    logic [TMR_W-1:0] tmr;     // bits 3:1: update interval code
    logic             master;  // bit 0: 1 = master mode
  } agc_ctrl_t;

  localparam int CTRL_W = $bits(agc_ctrl_t);
endpackage

// File: rtl/agc_level_est.sv
module agc_level_est #(
  parameter int SMP_W    = 6,
  parameter int WIN_LOG2 = 4,
  parameter int ACC_W    = 16,
  parameter int LVL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] smp_q,
  output logic [LVL_W-1:0] level,
  output logic             win_done
);
  localparam int SQ_W = 2 * SMP_W + 1;

  logic signed [SMP_W-1:0]   si, sq;
  logic signed [2*SMP_W-1:0] pi, pq;
  logic [SQ_W-1:0]           pwr;
  logic [ACC_W:0]            acc_sum;
  logic [ACC_W-1:0]          acc_sat;

  logic [ACC_W-1:0]    acc_q, acc_n;
  logic [WIN_LOG2-1:0] cnt_q, cnt_n;
  logic [LVL_W-1:0]    lvl_q, lvl_n;
  logic                done_q, done_n;

  always_comb begin
    si      = smp_i;
    sq      = smp_q;
    pi      = si * si;
    pq      = sq * sq;
    pwr     = SQ_W'($unsigned(pi)) + SQ_W'($unsigned(pq));
    acc_sum = {1'b0, acc_q} + (ACC_W + 1)'(pwr);
    acc_sat = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
  end

  always_comb begin
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    lvl_n  = lvl_q;
    done_n = 1'b0;
    if (vld) begin
      if (cnt_q == '1) begin
        lvl_n  = acc_sat[ACC_W-1 -: LVL_W];
        acc_n  = '0;
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        acc_n = acc_sat;
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      lvl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      cnt_q  <= cnt_n;
      lvl_q  <= lvl_n;
      done_q <= done_n;
    end
  end

  assign level    = lvl_q;
  assign win_done = done_q;
endmodule

// File: rtl/agc_gain_ctl.sv
module agc_gain_ctl #(
  parameter int                 GAIN_W   = 8,
  parameter int                 TMR_W    = 3,
  parameter int                 TMR_BASE = 4,
  parameter logic [GAIN_W-1:0]  GAIN_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic [TMR_W-1:0]  tmr,
  input  logic              win_done,
  input  logic [GAIN_W-1:0] level,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain
);
  localparam int CNT_W = TMR_BASE + (1 << TMR_W) - 1;

  logic [CNT_W:0]    span;
  logic [CNT_W-1:0]  last;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [GAIN_W-1:0] gain_q, gain_n;

  always_comb begin
    span   = (CNT_W + 1)'(1) << (TMR_BASE + int'(tmr));
    last   = CNT_W'(span - 1'b1);
    cnt_n  = cnt_q;
    gain_n = gain_q;
    if (!master) begin
      cnt_n = '0;
    end else if (win_done) begin
      if (cnt_q >= last) begin
        cnt_n = '0;
        if (level < target && gain_q != '1)
          gain_n = gain_q + 1'b1;
        else if (level > target && gain_q != '0)
          gain_n = gain_q - 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gain_q <= GAIN_RST;
    end else begin
      cnt_q  <= cnt_n;
      gain_q <= gain_n;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/agc_pwm_gen.sv
module agc_pwm_gen #(
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAIN_W-1:0] duty_in,
  input  logic              pos,
  output logic              pwm_out,
  output logic [GAIN_W-1:0] phase,
  output logic [GAIN_W-1:0] duty
);
  logic [GAIN_W-1:0] ph_q, ph_n;
  logic [GAIN_W-1:0] duty_q, duty_n;
  logic              hi;

  always_comb begin
    ph_n   = ph_q + 1'b1;
    duty_n = (ph_q == '1) ? duty_in : duty_q;
    hi     = ph_q < duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      duty_q <= '0;
    end else begin
      ph_q   <= ph_n;
      duty_q <= duty_n;
    end
  end

  assign pwm_out = pos ? hi : ~hi;
  assign phase   = ph_q;
  assign duty    = duty_q;
endmodule

// File: rtl/agc_pwm_loop.sv
module agc_pwm_loop
  import agc_pkg::*;
#(
  parameter int SMP_W    = 6,
  parameter int WIN_LOG2 = 4,
  parameter int ACC_W    = 16,
  parameter int DATA_W   = 8,
  parameter int TMR_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [SMP_W-1:0]  smp_q,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  localparam agc_ctrl_t CTRL_RST = '{pos: 1'b1, tmr: '0, master: 1'b0};

  logic [DATA_W-1:0] level;
  logic              win_done;
  logic [DATA_W-1:0] mgain;
  logic [DATA_W-1:0] gain_eff;
  logic [DATA_W-1:0] pwm_phase, pwm_duty;

  logic [DATA_W-1:0] tgt_q, tgt_n;
  agc_ctrl_t         ctrl_q, ctrl_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  agc_level_est #(
    .SMP_W(SMP_W), .WIN_LOG2(WIN_LOG2), .ACC_W(ACC_W), .LVL_W(DATA_W)
  ) u_est (
    .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .level(level), .win_done(win_done)
  );

  agc_gain_ctl #(
    .GAIN_W(DATA_W), .TMR_W(TMR_W), .TMR_BASE(TMR_BASE), .GAIN_RST(DATA_W'(1 << (DATA_W - 1)))
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .master(ctrl_q.master), .tmr(ctrl_q.tmr),
    .win_done(win_done), .level(level), .target(tgt_q), .gain(mgain)
  );

  assign gain_eff = ctrl_q.master ? mgain : tgt_q;

  agc_pwm_gen #(.GAIN_W(DATA_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty_in(gain_eff), .pos(ctrl_q.pos),
    .pwm_out(pwm_out), .phase(pwm_phase), .duty(pwm_duty)
  );

  always_comb begin
    tgt_n   = tgt_q;
    ctrl_n  = ctrl_q;
    rdata_n = rdata_q;
    if (reg_wr) begin
      if (reg_addr == ADR_GAIN) tgt_n  = reg_wdata;
      if (reg_addr == ADR_CTRL) ctrl_n = agc_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end
    if (reg_rd) begin
      case (reg_addr)
        ADR_LEVEL: rdata_n = level;
        ADR_GAIN:  rdata_n = tgt_q;
        ADR_CTRL:  rdata_n = {{(DATA_W - CTRL_W){1'b0}}, ctrl_q};
        default:   rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      ctrl_q  <= CTRL_RST;
      rdata_q <= '0;
    end else begin
      tgt_q   <= tgt_n;
      ctrl_q  <= ctrl_n;
      rdata_q <= rdata_n;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/agc_pwm_loop_chk.sv
module agc_pwm_loop_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] level,
  input logic              win_done,
  input logic              master,
  input logic [DATA_W-1:0] mgain,
  input logic [DATA_W-1:0] pwm_phase,
  input logic [DATA_W-1:0] pwm_duty
);
  // R3: level only moves together with a window-closure pulse
  a_r3_level_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> win_done);

  // R5: read data only moves after a read strobe
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> $stable(reg_rdata));

  // R7: internal gain changes only after a window closure in master mode
  a_r7_gain_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mgain) |-> ($past(win_done) && $past(master)));

  // R7: internal gain moves by a single step
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mgain) |-> (mgain == DATA_W'($past(mgain) + 1'b1) ||
                         mgain == DATA_W'($past(mgain) - 1'b1)));

  // R9: duty latched only when a period wraps
  a_r9_duty_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_duty) |-> ($past(pwm_phase) == '1));

  // R11: internal gain frozen while in slave mode
  a_r11_slave_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && $past(!master)) |-> $stable(mgain));
endmodule

bind agc_pwm_loop agc_pwm_loop_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .level(level), .win_done(win_done), .master(ctrl_q.master), .mgain(mgain),
  .pwm_phase(pwm_phase), .pwm_duty(pwm_duty)
);

// File: tb/test_agc_pwm_loop.sv
module test_agc_pwm_loop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic [5:0] smp_i = '0, smp_q = '0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  agc_pwm_loop i_agc_pwm_loop (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
  endtask

  function automatic int lvl_of(input int s);
    if (s > 65535) s = 65535;
    return s / 256;
  endfunction

  // one window of 16 valid samples, random or constant, with optional gaps
  task automatic send_win(input bit rnd, input int ci, input int cq, input bit gaps, output int exp);
    int s = 0;
    for (int k = 0; k < 16; k++) begin
      int ii = rnd ? int'($urandom_range(0, 63)) - 32 : ci;
      int qq = rnd ? int'($urandom_range(0, 63)) - 32 : cq;
      @(negedge clk); smp_vld = 1'b1; smp_i = 6'(ii); smp_q = 6'(qq);
      s += ii * ii + qq * qq;
      if (gaps) begin
        int g = int'($urandom_range(0, 3));
        for (int j = 0; j < g; j++) begin
          @(negedge clk); smp_vld = 1'b0; smp_i = 6'($urandom); smp_q = 6'($urandom);
        end
      end
    end
    @(negedge clk); smp_vld = 1'b0;
    exp = lvl_of(s);
  endtask

  task automatic send_n(input int n, input int ci, input int cq);
    int e;
    for (int w = 0; w < n; w++) send_win(1'b0, ci, cq, 1'b0, e);
  endtask

  task automatic high_time(output int h);
    h = 0;
    repeat (520) @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      if (pwm_out) h++;
      @(negedge clk);
    end
  endtask

  initial begin
    int d, e, h, run;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'h0, d); check("R1 level", d, 8'h00);
    rd(3'h4, d); check("R1 gain", d, 8'h00);
    rd(3'h7, d); check("R1 ctrl", d, 8'h10);
    high_time(h); check("R1 pwm low", h, 0);

    // R2 random windows with gaps, plus directed extremes
    for (int t = 0; t < 8; t++) begin
      send_win(1'b1, 0, 0, 1'b1, e);
      rd(3'h0, d); check("R2 random window", d, e);
    end
    send_win(1'b0, -32, -32, 1'b0, e);
    rd(3'h0, d); check("R2 full negative", d, e);
    send_win(1'b0, 31, -32, 1'b1, e);
    rd(3'h0, d); check("R2 mixed extremes", d, e);

    // R3 idle samples ignored
    repeat (40) begin
      @(negedge clk); smp_i = 6'($urandom); smp_q = 6'($urandom);
    end
    rd(3'h0, d); check("R3 level held", d, e);

    // R4 map: unused address
    wr(3'h2, 8'hAA);
    rd(3'h2, d); check("R4 unused reads 0", d, 0);
    rd(3'h4, d); check("R4 gain untouched", d, 0);
    rd(3'h7, d); check("R4 ctrl untouched", d, 8'h10);
    wr(3'h7, 8'hF0);
    rd(3'h7, d); check("R4 ctrl upper bits", d, 8'h10);

    // R5 read data holds without strobe
    rd(3'h7, d);
    @(negedge clk); reg_addr = 3'h0;
    repeat (5) @(negedge clk);
    check("R5 rdata hold", int'(reg_rdata), 8'h10);

    // R9 boundary: new value mid-pulse applies next period
    wr(3'h4, 8'h80);
    e = 0;
    while (!pwm_out && e < 600) begin @(negedge clk); e++; end
    run = 0;
    for (int k = 0; k < 300 && pwm_out; k++) begin
      run++;
      if (k == 10) begin reg_addr = 3'h4; reg_wdata = 8'h20; reg_wr = 1'b1; end
      if (k == 11) reg_wr = 1'b0;
      @(negedge clk);
    end
    check("R9 pulse keeps old width", run, 8'h80);
    e = 0;
    while (!pwm_out && e < 600) begin @(negedge clk); e++; end
    run = 0;
    for (int k = 0; k < 300 && pwm_out; k++) begin run++; @(negedge clk); end
    check("R9 next pulse new width", run, 8'h20);

    // R6 slave: level does not steer duty
    send_n(4, 16, 16);
    high_time(h); check("R6 slave duty", h, 8'h20);

    // R10 inverted polarity
    wr(3'h7, 8'h00);
    high_time(h); check("R10 inverted", h, 256 - 8'h20);

    // R1 internal gain, R7 down steps (level 20h above target 10h)
    wr(3'h4, 8'h10);
    wr(3'h7, 8'h11);
    high_time(h); check("R1 master start gain", h, 8'h80);
    send_n(48, 16, 16);
    high_time(h); check("R7 down three steps", h, 8'h7D);
    wr(3'h4, 8'h20);
    send_n(16, 16, 16);
    high_time(h); check("R7 equal holds", h, 8'h7D);
    wr(3'h4, 8'h30);
    wr(3'h7, 8'h13);
    send_n(31, 16, 16);
    high_time(h); check("R7 interval code 1 not yet", h, 8'h7D);
    send_n(1, 16, 16);
    high_time(h); check("R7 interval code 1 step up", h, 8'h7E);

    // R8 saturation high then low
    wr(3'h4, 8'hFF);
    wr(3'h7, 8'h11);
    send_n(131 * 16, 0, 0);
    high_time(h); check("R8 saturate FF", h, 255);
    wr(3'h4, 8'h00);
    send_n(257 * 16, 16, 16);
    high_time(h); check("R8 saturate 00", h, 0);

    // R11 slave mode freezes internal gain and counter
    wr(3'h4, 8'h40);
    wr(3'h7, 8'h10);
    send_n(20, 16, 16);
    high_time(h); check("R11 slave uses register", h, 8'h40);
    wr(3'h4, 8'hFF);
    wr(3'h7, 8'h11);
    high_time(h); check("R11 gain retained", h, 0);
    send_n(15, 0, 0);
    high_time(h); check("R11 counter restarted", h, 0);
    send_n(1, 0, 0);
    high_time(h); check("R11 resume step", h, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule